// File: doc/BRIEF.md
# Clock Select and Sleep Controller

This block chooses where a small microcontroller takes its CPU clock from and what appears on its clock-output pin. It also handles sleep and wake, and it remembers what caused the last reset. Each oscillator is modelled as a one-cycle enable pulse on a common system clock: `fast_tick` comes from the internal fast oscillator, `slow_tick` from the internal low-power oscillator, and `ext_tick` from the external clock. The CPU clock and the clock output are produced as pulses of the same kind.

Software reaches three byte-wide registers through a write port and a combinational read port:
- Address 0 is the output-select register.
- Address 1 is the CPU source register.
- Address 2 holds the reset-cause flags.

The CPU normally runs from the fast oscillator divided by eight. It can be moved to the external clock, and the move is made with a handover in which no pulses overlap. A sleep request forces the CPU back onto the internal source and stops the fast oscillator. After a wake request, the CPU clock stays gated until three slow-oscillator pulses have passed.

Top module: `clksel_ctrl`

## Requirements
- R1: Register 0 holds the output-select field in bits 1:0. Bits 7:2 read as zero. Register 1 holds the CPU source bit in bit 0, where 0 selects the internal divided clock and 1 selects the external clock, and its other bits read as zero. Both registers read 0x00 after any reset.
- R2: `clkout_tick` follows the field in register 0: 00 gives the running fast oscillator, 01 gives `ext_tick`, 10 gives `slow_tick`, and 11 gives `cpu_tick`.
- R3: While `asleep` is 1, including during wake recovery, select code 10 holds `clkout_tick` at 0.
- R4: On the internal source, `cpu_tick` fires once for every 8 `fast_tick` pulses. After reset the first pulse comes on the 8th fast pulse.
- R5: A sleep request sets `asleep`, clears register 1 to the internal source, and drops `fast_run`. It also suppresses `cpu_tick` and the fast-oscillator clock output.
- R6: After a wake request, `fast_run` returns in the next cycle. `asleep` clears in the cycle after the 3rd `slow_tick`. The divider then restarts, so the first `cpu_tick` comes on the 8th fast pulse.
- R7: A wake request during recovery does not restart the count of three, and a sleep request while asleep has no effect.
- R8: Power-on reset (`por_n` low) sets the status register to 0x01: bit 0 is the power-on flag and bit 1 is the watchdog flag.
- R9: A watchdog pulse on `wdr` returns registers 0 and 1 to 0x00, leaves sleep, sets status bit 1, and keeps status bit 0 unchanged.
- R10: Writing 1 to a status bit clears that bit. Writing 0 to it leaves it as it was.
- R11: After the CPU source bit changes, the next pulse of the old source is swallowed, then the next two pulses of the new source are swallowed. From the third new pulse onward, pulses pass. No `cpu_tick` occurs during the handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wdr | input | 1 | Synchronous watchdog reset pulse |
| fast_tick | input | 1 | Fast internal oscillator enable pulse |
| slow_tick | input | 1 | Slow low-power oscillator enable pulse |
| ext_tick | input | 1 | External clock enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| sleep_req | input | 1 | Sleep entry request |
| wake_req | input | 1 | Wake request |
| cpu_tick | output | 1 | CPU clock enable pulse |
| clkout_tick | output | 1 | Clock-output pin pulse |
| fast_run | output | 1 | Fast oscillator run control |
| asleep | output | 1 | Sleep or wake-recovery in progress |

## Verification
A wrong handover phase appears on `cpu_tick` at the first pulse of the new source: a pulse arrives one or two pulses early, or no pulse arrives at all. A wrong recovery count shows on `asleep` and on the first CPU pulse after wake, within three slow pulses. A bad divider count shifts the first CPU pulse after reset or wake within eight fast pulses. A wrong flag update is visible when the status register is read right after the reset or write that caused it.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
  typedef enum logic [1:0] {
    OUT_FAST = 2'b00, OUT_EXT = 2'b01, OUT_SLOW = 2'b10, OUT_CPU = 2'b11
  } out_sel_e;
  typedef enum logic [1:0] {PH_RUN, PH_DROP, PH_SYNC1, PH_SYNC2} phase_e;

  localparam logic [1:0] ADDR_OUT  = 2'd0;
  localparam logic [1:0] ADDR_CPU  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // last count value before the divider wraps
  function automatic logic div_at_end(int unsigned cnt, int unsigned div);
    return cnt == div - 1;
  endfunction

  function automatic logic [7:0] status_word(logic por_f, logic wdr_f);
    return {6'b0, wdr_f, por_f};
  endfunction
endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       wdr,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  input  logic       sleep_enter,
  output logic [7:0] rd_data,
  output out_sel_e   out_sel,
  output src_e       cpu_sel,
  output logic       por_flag,
  output logic       wdr_flag
);
  logic wr_out, wr_cpu, wr_stat;
  assign wr_out  = wr_en && wr_addr == ADDR_OUT;
  assign wr_cpu  = wr_en && wr_addr == ADDR_CPU;
  assign wr_stat = wr_en && wr_addr == ADDR_STAT;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      out_sel  <= OUT_FAST;
      cpu_sel  <= SRC_INT;
      por_flag <= 1'b1;
      wdr_flag <= 1'b0;
    end else if (wdr) begin
      out_sel  <= OUT_FAST;
      cpu_sel  <= SRC_INT;
      wdr_flag <= 1'b1;
    end else begin
      if (wr_out) out_sel <= out_sel_e'(wr_data[1:0]);
      if (sleep_enter) cpu_sel <= SRC_INT;
      else if (wr_cpu) cpu_sel <= src_e'(wr_data[0]);
      if (wr_stat && wr_data[0]) por_flag <= 1'b0;
      if (wr_stat && wr_data[1]) wdr_flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_OUT:  rd_data = {6'b0, out_sel};
      ADDR_CPU:  rd_data = {7'b0, cpu_sel};
      ADDR_STAT: rd_data = status_word(por_flag, wdr_flag);
      default:   rd_data = 8'h00;
    endcase
  end

  assert_wdr_keeps_por_R9: assert property (@(posedge clk) disable iff (!por_n)
    wdr |=> wdr_flag && por_flag == $past(por_flag));
  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!wdr && wr_stat && wr_data[1]) |=> !wdr_flag);
endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
  import clksel_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   wdr,
  input  src_e   sel_req,
  input  logic   force_int,
  input  logic   int_tick,
  input  logic   ext_tick,
  output src_e   cur_src,
  output phase_e phase
);
  logic cur_pulse;
  assign cur_pulse = (cur_src == SRC_INT) ? int_tick : ext_tick;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cur_src <= SRC_INT;
      phase   <= PH_RUN;
    end else if (wdr || force_int) begin
      cur_src <= SRC_INT;
      phase   <= PH_RUN;
    end else begin
      case (phase)
        PH_RUN:   if (sel_req != cur_src) phase <= PH_DROP;
        PH_DROP:  if (cur_pulse) begin
                    cur_src <= src_e'(~cur_src);
                    phase   <= PH_SYNC1;
                  end
        PH_SYNC1: if (cur_pulse) phase <= PH_SYNC2;
        PH_SYNC2: if (cur_pulse) phase <= PH_RUN;
        default:  phase <= PH_RUN;
      endcase
    end
  end

  assert_src_flips_on_old_R11: assert property (@(posedge clk) disable iff (!por_n || wdr || force_int)
    (phase == PH_DROP && !cur_pulse) |=> phase == PH_DROP && $stable(cur_src));
endmodule

// File: rtl/clksel_wake.sv
module clksel_wake #(
  parameter int unsigned RECOV = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic wdr,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic slow_tick,
  output logic sleeping,
  output logic sleep_enter,
  output logic fast_run
);
  localparam int unsigned CW = (RECOV > 1) ? $clog2(RECOV) : 1;
  localparam logic [CW-1:0] LAST = CW'(RECOV - 1);

  logic          recov;
  logic [CW-1:0] cnt;
  logic          release_now;

  assign sleep_enter = sleep_req && !sleeping && !wdr;
  assign release_now = recov && slow_tick && cnt == LAST;
  assign fast_run    = !sleeping || recov;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sleeping <= 1'b0;
      recov    <= 1'b0;
      cnt      <= '0;
    end else if (wdr) begin
      sleeping <= 1'b0;
      recov    <= 1'b0;
      cnt      <= '0;
    end else if (!sleeping) begin
      if (sleep_req) sleeping <= 1'b1;
    end else if (!recov) begin
      if (wake_req) begin
        recov <= 1'b1;
        cnt   <= '0;
      end
    end else if (release_now) begin
      sleeping <= 1'b0;
      recov    <= 1'b0;
      cnt      <= '0;
    end else if (slow_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!por_n || wdr)
    (recov && wake_req && !slow_tick) |=> cnt == $past(cnt) && recov);
  assert_release_on_slow_R6: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(sleeping) && !$past(wdr)) |-> $past(slow_tick) && $past(recov));
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int unsigned DIV   = 8,
  parameter int unsigned RECOV = 3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wdr,
  input  logic       fast_tick,
  input  logic       slow_tick,
  input  logic       ext_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sleep_req,
  input  logic       wake_req,
  output logic       cpu_tick,
  output logic       clkout_tick,
  output logic       fast_run,
  output logic       asleep
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  out_sel_e      out_sel;
  src_e          cpu_sel;
  src_e          cur_src;
  phase_e        phase;
  logic          por_flag, wdr_flag;
  logic          sleeping, sleep_enter;
  logic [DW-1:0] div_cnt;
  logic          int_tick, fast_live, gate_on;

  clksel_regs u_regs (
    .clk(clk), .por_n(por_n), .wdr(wdr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sleep_enter(sleep_enter),
    .rd_data(rd_data), .out_sel(out_sel), .cpu_sel(cpu_sel),
    .por_flag(por_flag), .wdr_flag(wdr_flag)
  );

  clksel_wake #(.RECOV(RECOV)) u_wake (
    .clk(clk), .por_n(por_n), .wdr(wdr), .sleep_req(sleep_req),
    .wake_req(wake_req), .slow_tick(slow_tick), .sleeping(sleeping),
    .sleep_enter(sleep_enter), .fast_run(fast_run)
  );

  clksel_switch u_switch (
    .clk(clk), .por_n(por_n), .wdr(wdr), .sel_req(cpu_sel),
    .force_int(sleep_enter), .int_tick(int_tick), .ext_tick(ext_tick),
    .cur_src(cur_src), .phase(phase)
  );

  assign fast_live = fast_tick && fast_run;
  assign int_tick  = fast_live && !sleeping && div_at_end(32'(div_cnt), DIV);
  assign gate_on   = phase == PH_RUN && !sleeping;
  assign cpu_tick  = gate_on && ((cur_src == SRC_INT) ? int_tick : ext_tick);
  assign asleep    = sleeping;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                div_cnt <= '0;
    else if (wdr || sleeping)  div_cnt <= '0;
    else if (fast_live)        div_cnt <= div_at_end(32'(div_cnt), DIV) ? '0 : div_cnt + 1'b1;
  end

  always_comb begin
    case (out_sel)
      OUT_FAST: clkout_tick = fast_live;
      OUT_EXT:  clkout_tick = ext_tick;
      OUT_SLOW: clkout_tick = slow_tick && !sleeping;
      default:  clkout_tick = cpu_tick;
    endcase
  end

  assert_slow_held_R3: assert property (@(posedge clk) disable iff (!por_n)
    (asleep && out_sel == OUT_SLOW) |-> !clkout_tick);
  assert_no_cpu_in_sleep_R5: assert property (@(posedge clk) disable iff (!por_n)
    asleep |-> !cpu_tick);
  assert_sleep_forces_int_R5: assert property (@(posedge clk) disable iff (!por_n || wdr)
    sleep_enter |=> cpu_sel == SRC_INT && cur_src == SRC_INT && !fast_run);
  assert_handover_quiet_R11: assert property (@(posedge clk) disable iff (!por_n)
    (phase != PH_RUN) |-> !cpu_tick);
endmodule

// File: tb/clksel_ctrl_bench.sv
module clksel_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, por_n = 1'b0, wdr = 1'b0;
  logic fast_tick = 1'b0, slow_tick = 1'b0, ext_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic cpu_tick, clkout_tick, fast_run, asleep;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clksel_ctrl u_clksel_ctrl (
    .clk(clk), .por_n(por_n), .wdr(wdr), .fast_tick(fast_tick),
    .slow_tick(slow_tick), .ext_tick(ext_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake_req(wake_req),
    .cpu_tick(cpu_tick), .clkout_tick(clkout_tick), .fast_run(fast_run),
    .asleep(asleep)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of oscillator pulses; outputs sampled before the edge
  task automatic cyc(input logic f, input logic s, input logic e,
                     output logic c, output logic o);
    fast_tick = f; slow_tick = s; ext_tick = e;
    #1;
    c = cpu_tick; o = clkout_tick;
    @(negedge clk);
    fast_tick = 0; slow_tick = 0; ext_tick = 0;
  endtask

  task automatic idle(input int n);
    logic c, o;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, c, o);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    logic c, o;
    logic [7:0] d;
    int cnt;
    @(negedge clk); @(negedge clk);
    por_n = 1;
    @(negedge clk);
    // R1 R8 reset state
    rd(0, d); chk("R1 out reg reset", d, 8'h00);
    rd(1, d); chk("R1 cpu reg reset", d, 8'h00);
    rd(2, d); chk("R8 status after por", d, 8'h01);
    // R4 first tick on 8th fast pulse
    for (int k = 0; k < 8; k++) begin
      cyc(1, 0, 0, c, o); chk("R4 first divide", 8'(c), 8'(k == 7));
    end
    cnt = 0;
    for (int k = 0; k < 32; k++) begin
      cyc(k % 2 == 0, 0, 0, c, o); cnt += c;
    end
    chk("R4 sparse fast count", 8'(cnt), 8'd2);
    // R2 exhaustive output mux sweep
    for (int s = 0; s < 4; s++) begin
      wr(0, 8'(s));
      for (int m = 0; m < 8; m++) begin
        logic ef, es, ee, ex;
        ef = m[0]; es = m[1]; ee = m[2];
        cyc(ef, es, ee, c, o);
        ex = (s == 0) ? ef : (s == 1) ? ee : (s == 2) ? es : c;
        chk("R2 clkout select", 8'(o), 8'(ex));
      end
    end
    // R1 reserved bits
    wr(0, 8'hFF); rd(0, d); chk("R1 reserved out bits", d, 8'h03);
    wr(1, 8'hFF); rd(1, d); chk("R1 reserved cpu bits", d, 8'h01);
    // R11 handover internal -> external
    idle(2);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin cyc(0, 0, 1, c, o); cnt += c; end
    for (int k = 0; k < 8; k++) begin cyc(1, 0, 0, c, o); cnt += c; end
    chk("R11 quiet before old drop", 8'(cnt), 8'd0);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 1, c, o); chk("R11 new pulses", 8'(c), 8'(k >= 2));
    end
    // R11 handover external -> internal
    wr(1, 8'h00); idle(2);
    cyc(0, 0, 1, c, o); chk("R11 old ext dropped", 8'(c), 8'd0);
    cnt = 0;
    for (int k = 0; k < 24; k++) begin cyc(1, 0, 0, c, o); cnt += c; end
    chk("R11 third int pulse only", 8'(cnt), 8'd1);
    // go to external again, then sleep
    wr(1, 8'h01); idle(2);
    for (int k = 0; k < 8; k++) cyc(1, 0, 0, c, o);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, c, o);
    cyc(0, 0, 1, c, o); chk("R11 ext running", 8'(c), 8'd1);
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    rd(1, d); chk("R5 sleep forces internal", d, 8'h00);
    chk("R5 asleep", 8'(asleep), 8'd1);
    chk("R5 fast stopped", 8'(fast_run), 8'd0);
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    chk("R7 second sleep ignored", 8'(fast_run), 8'd0);
    wr(0, 8'h02);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 1, c, o); cnt += c;
      chk("R3 slow held in sleep", 8'(o), 8'd0);
    end
    chk("R5 no cpu in sleep", 8'(cnt), 8'd0);
    wr(0, 8'h00);
    cyc(1, 0, 0, c, o); chk("R5 fast out stopped", 8'(o), 8'd0);
    // R6 R7 wake recovery
    wr(0, 8'h02);
    wake_req = 1; @(negedge clk); wake_req = 0;
    chk("R6 fast restarts", 8'(fast_run), 8'd1);
    cyc(0, 1, 0, c, o); chk("R3 slow held in recovery", 8'(o), 8'd0);
    wake_req = 1; cyc(1, 1, 0, c, o); wake_req = 0;
    chk("R6 gated in recovery", 8'(c), 8'd0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, c, o);
    chk("R7 still recovering", 8'(asleep), 8'd1);
    cyc(0, 1, 0, c, o);
    chk("R7 release after third slow", 8'(asleep), 8'd0);
    for (int k = 0; k < 8; k++) begin
      cyc(1, 0, 0, c, o); chk("R6 divider restart", 8'(c), 8'(k == 7));
    end
    cyc(0, 1, 0, c, o); chk("R3 slow passes awake", 8'(o), 8'd1);
    // R10 R9 R8 status
    wr(2, 8'h00); rd(2, d); chk("R10 write 0 keeps", d, 8'h01);
    wr(2, 8'h01); rd(2, d); chk("R10 w1c por", d, 8'h00);
    wr(0, 8'h03); wr(1, 8'h01);
    wdr = 1; @(negedge clk); wdr = 0;
    rd(2, d); chk("R9 wdr flag", d, 8'h02);
    rd(0, d); chk("R9 out reg default", d, 8'h00);
    rd(1, d); chk("R9 cpu reg default", d, 8'h00);
    wr(2, 8'h02); rd(2, d); chk("R10 w1c wdr", d, 8'h00);
    por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    rd(2, d); chk("R8 por again", d, 8'h01);
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    chk("R5 asleep again", 8'(asleep), 8'd1);
    wdr = 1; @(negedge clk); wdr = 0;
    rd(2, d); chk("R9 por kept", d, 8'h03);
    chk("R9 sleep left", 8'(asleep), 8'd0);
    finish_run();
  end
endmodule